// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block watches the command pins of a DDR SDRAM bus from the memory side. On every rising clock edge it takes the two clock-enable samples, the chip select, the three strobe pins, the address bus and the bank address. It turns them into one command code, keeps an idle or active flag for each of four banks, and follows the low-power state of the device. One clock after the sample, the command code, the bank flags, the low-power state and a single-cycle error pulse appear on registered outputs.

A read or write that asks for auto-precharge sets a countdown on its bank. The length of the countdown depends on the burst length, the precharge time and, for writes, the write recovery time. While the countdown runs, any command aimed at that bank is rejected. Loads of the base and extended mode registers are accepted only when every bank is idle, no countdown is running and the precharge time has passed since the last precharge. The stored register contents are available on outputs, and the DLL-off and half-drive bits of the extended register also have their own outputs. A command that is rejected raises the error pulse and changes no state.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When reset is asserted, every bank goes idle, every countdown is cleared, both mode registers hold zero, the error output is low, the command code is 0 (deselect) and the low-power state is 0 (normal).
- R2: With both clock-enable samples high, the command code seen one cycle after the sample is: chip select high gives 0 (deselect). For chip select low, the pin patterns of RAS, CAS and WE map as follows: HHH gives 1 (no-op), LHH 2 (activate), HLH 3 (read, or 4 if A10 is high), HLL 5 (write, or 6 if A10 is high), LHL 7 (precharge, or 8 if A10 is high), HHL 9 (burst stop), LLH 10 (auto refresh), LLL 11 (mode load, or 12 if BA0 is high).
- R3: An activate to an idle, unlocked bank makes that bank active. An activate to a bank that is already active raises the error output.
- R4: A read or write to an idle bank raises the error output. No rejected command changes the bank flags, the countdowns or the mode registers.
- R5: A precharge with A10 high idles all banks and ignores BA. A precharge with A10 low idles only the bank that BA selects.
- R6: A read with auto-precharge accepted at cycle n idles its bank. Any command to that bank is then rejected up to cycle n + BL/2 + tRP, which is the first cycle in which such a command is accepted.
- R7: A write with auto-precharge accepted at cycle n idles its bank, and the bank is locked until cycle n + BL/2 + 1 + tWR + tRP.
- R8: A mode register load is accepted only if all banks are idle, no bank is locked and at least tRP cycles have passed since the last accepted precharge. A load issued exactly tRP cycles after the precharge is accepted. Any other load raises the error output and changes neither register.
- R9: In a mode load, BA0 low writes A0-A12 into the base register whatever the value of BA1. BA0=1 with BA1=0 selects the extended register. BA0=1 with BA1=1 is rejected.
- R10: In an accepted extended load, A0 drives the DLL-off output and A1 drives the half-drive output. An extended load with A2 set, or with any bit from A3 to A12 set, is rejected.
- R11: An auto-refresh pattern sampled while clock enable falls gives code 13 (self-refresh entry) and low-power state 1 if all banks are idle. If any bank is active it raises the error output instead and the state stays 0. When clock enable rises again, the code is 15 (exit) and the state returns to 0.
- R12: A no-op or deselect sampled while clock enable falls gives code 14 and low-power state 2 if all banks are idle, or 3 if any bank is active. Any other command on a falling clock enable is rejected. While both samples are low, the code is 1 and the bank inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_prev | input | 1 | Clock-enable sample of the previous cycle |
| cke_cur | input | 1 | Clock-enable sample of this cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Address bus; bit 10 selects auto-precharge or all banks |
| ba | input | 2 | Bank address |
| cmd_code | output | 4 | Decoded command code (R2, R11, R12) |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |
| bank_active | output | 4 | One bit per bank, 1 = active |
| lp_state | output | 2 | 0 normal, 1 self refresh, 2 precharge power-down, 3 active power-down |
| mode_base | output | 13 | Base mode register contents |
| mode_ext | output | 13 | Extended mode register contents |
| dll_off | output | 1 | Extended register bit 0 |
| half_drive | output | 1 | Extended register bit 1 |

## Verification
Every command pattern is driven to banks in each state. An activate to an active bank, and a read or write to an idle one, show that the decoder and the bank state interact correctly. The auto-precharge tests issue activates one cycle before and exactly at the lockout limit, for both reads and writes. This detects an off-by-one error or a swap between the two window lengths. Mode loads are tried with an active bank, during a lockout, one and two cycles after a precharge and exactly tRP cycles after it, and with each bank-address combination and reserved bit. Clock-enable falls are tried with idle banks, with an active bank and with an illegal command, to separate the two power-down states, the self-refresh case and the rejected case.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,  CMD_NOP  = 4'd1,  CMD_ACT  = 4'd2,  CMD_RD   = 4'd3,
    CMD_RDA   = 4'd4,  CMD_WR   = 4'd5,  CMD_WRA  = 4'd6,  CMD_PRE  = 4'd7,
    CMD_PREA  = 4'd8,  CMD_BST  = 4'd9,  CMD_REF  = 4'd10, CMD_MRS  = 4'd11,
    CMD_EMRS  = 4'd12, CMD_SRE  = 4'd13, CMD_PDE  = 4'd14, CMD_PDX  = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0, LP_SELF = 2'd1, LP_PPD = 2'd2, LP_APD = 2'd3
  } lp_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic a10,
  input  logic ba0,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_DESEL;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b110:  cmd = CMD_BST;
        3'b001:  cmd = CMD_REF;
        default: cmd = ba0 ? CMD_EMRS : CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int CW   = 4,
  parameter int L_RD = 5,
  parameter int L_WR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_act,
  input  logic clr_act,
  input  logic load_rd,
  input  logic load_wr,
  output logic active,
  output logic locked
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr)           cnt_d = CW'(L_WR - 1);
    else if (load_rd)      cnt_d = CW'(L_RD - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    act_d = act_q;
    if (set_act)      act_d = 1'b1;
    else if (clr_act) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;
  assign locked = (cnt_q != '0);

  AST_LOCK_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !act_q); // R6
  AST_LOCK_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !load_rd && !load_wr) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R7
endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs #(
  parameter int AW   = 13,
  parameter int BW   = 2,
  parameter int T_RP = 3,
  parameter int RW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [BW-1:0] ba,
  input  logic [AW-1:0] addr,
  input  logic          all_idle,
  input  logic          no_lock,
  input  logic          pre_evt,
  output logic          fault,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] ext_q
);
  logic [RW-1:0] rp_q, rp_d;
  logic          sel_ext, bad_ba, rsvd;
  logic          wr_base, wr_ext;

  always_comb begin
    rp_d = rp_q;
    if (pre_evt)          rp_d = RW'(T_RP - 1);
    else if (rp_q != '0)  rp_d = rp_q - RW'(1);
  end

  assign sel_ext = (ba == BW'(1));
  assign bad_ba  = ba[0] && !sel_ext;
  assign rsvd    = sel_ext && (addr[AW-1:2] != '0);
  assign fault   = !all_idle || !no_lock || (rp_q != '0) || bad_ba || rsvd;
  assign wr_base = req && !fault && !ba[0];
  assign wr_ext  = req && !fault && sel_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q   <= '0;
      base_q <= '0;
      ext_q  <= '0;
    end else begin
      rp_q <= rp_d;
      if (wr_base) base_q <= addr;
      if (wr_ext)  ext_q  <= addr;
    end
  end

  AST_LOAD_WAITS_RP: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_q != '0) |=> ($stable(base_q) && $stable(ext_q))); // R8
  AST_EXT_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q[AW-1:2] == '0); // R10
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int AW   = 13,
  parameter int NB   = 4,
  parameter int BL   = 4,
  parameter int T_RP = 3,
  parameter int T_WR = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke_prev,
  input  logic                  cke_cur,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [AW-1:0]         addr,
  input  logic [$clog2(NB)-1:0] ba,
  output logic [3:0]            cmd_code,
  output logic                  cmd_err,
  output logic [NB-1:0]         bank_active,
  output logic [1:0]            lp_state,
  output logic [AW-1:0]         mode_base,
  output logic [AW-1:0]         mode_ext,
  output logic                  dll_off,
  output logic                  half_drive
);
  localparam int BW   = $clog2(NB);
  localparam int L_RD = BL / 2 + T_RP;
  localparam int L_WR = BL / 2 + 1 + T_WR + T_RP;
  localparam int CW   = $clog2(L_WR + 1);
  localparam int RW   = $clog2(T_RP + 1);

  cmd_e          dec, code_d, cmd_q;
  lp_e           lp_d, lp_q;
  logic          illegal, err_q;
  logic [NB-1:0] act_v, lock_v, set_act, clr_act, ld_rd, ld_wr, sel;
  logic          mr_req, mr_fault, pre_evt, both_hi;

  sdram_cmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10  (addr[10]), .ba0(ba[0]), .cmd(dec)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_slot #(.CW(CW), .L_RD(L_RD), .L_WR(L_WR)) u_bank (
      .clk    (clk),        .rst_n  (rst_n),
      .set_act(set_act[g]), .clr_act(clr_act[g]),
      .load_rd(ld_rd[g]),   .load_wr(ld_wr[g]),
      .active (act_v[g]),   .locked (lock_v[g])
    );
  end

  assign both_hi = cke_prev && cke_cur;
  assign mr_req  = both_hi && (dec == CMD_MRS || dec == CMD_EMRS);
  assign sel     = NB'(1) << ba;

  sdram_mode_regs #(.AW(AW), .BW(BW), .T_RP(T_RP), .RW(RW)) u_mr (
    .clk     (clk),       .rst_n  (rst_n),
    .req     (mr_req),    .ba     (ba),      .addr(addr),
    .all_idle(~|act_v),   .no_lock(~|lock_v),
    .pre_evt (pre_evt),   .fault  (mr_fault),
    .base_q  (mode_base), .ext_q  (mode_ext)
  );

  always_comb begin
    code_d  = dec;
    lp_d    = lp_q;
    illegal = 1'b0;
    set_act = '0;
    clr_act = '0;
    ld_rd   = '0;
    ld_wr   = '0;
    pre_evt = 1'b0;
    if (!cke_prev) begin
      if (cke_cur) begin
        code_d = CMD_PDX;
        lp_d   = LP_NONE;
      end else begin
        code_d = CMD_NOP;
      end
    end else if (!cke_cur) begin
      if (dec == CMD_REF) begin
        code_d = CMD_SRE;
        if (|act_v) illegal = 1'b1;
        else        lp_d = LP_SELF;
      end else if (dec == CMD_NOP || dec == CMD_DESEL) begin
        code_d = CMD_PDE;
        lp_d   = (|act_v) ? LP_APD : LP_PPD;
      end else begin
        illegal = 1'b1;
      end
    end else begin
      case (dec)
        CMD_ACT:
          if (|((act_v | lock_v) & sel)) illegal = 1'b1;
          else                           set_act = sel;
        CMD_RD, CMD_WR:
          if (!(|(act_v & sel))) illegal = 1'b1;
        CMD_RDA, CMD_WRA:
          if (!(|(act_v & sel))) illegal = 1'b1;
          else begin
            clr_act = sel;
            if (dec == CMD_RDA) ld_rd = sel;
            else                ld_wr = sel;
          end
        CMD_PRE:
          if (|(lock_v & sel)) illegal = 1'b1;
          else begin
            clr_act = sel;
            pre_evt = 1'b1;
          end
        CMD_PREA:
          if (|lock_v) illegal = 1'b1;
          else begin
            clr_act = '1;
            pre_evt = 1'b1;
          end
        CMD_MRS, CMD_EMRS:
          illegal = mr_fault;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_DESEL;
      err_q <= 1'b0;
      lp_q  <= LP_NONE;
    end else begin
      cmd_q <= code_d;
      err_q <= illegal;
      lp_q  <= lp_d;
    end
  end

  assign cmd_code    = cmd_q;
  assign cmd_err     = err_q;
  assign lp_state    = lp_q;
  assign bank_active = act_v;
  assign dll_off     = mode_ext[0];
  assign half_drive  = mode_ext[1];

  AST_REJECT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(act_v)); // R4
  AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_prev && !cke_cur) |=> ($stable(act_v) && !err_q)); // R12
  AST_DOUBLE_ACT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (both_hi && dec == CMD_ACT && (act_v & sel) != '0) |=> err_q); // R3
endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
module sdram_cmd_tracker_tb_top;
  import sdram_trk_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic cke_prev, cke_cur, cs_n, ras_n, cas_n, we_n;
  logic [12:0] addr;
  logic [1:0]  ba;
  logic [3:0]  cmd_code;
  logic        cmd_err, dll_off, half_drive;
  logic [3:0]  bank_active;
  logic [1:0]  lp_state;
  logic [12:0] mode_base, mode_ext;

  always #4 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke_cur(cke_cur),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .cmd_code(cmd_code), .cmd_err(cmd_err),
    .bank_active(bank_active), .lp_state(lp_state),
    .mode_base(mode_base), .mode_ext(mode_ext),
    .dll_off(dll_off), .half_drive(half_drive)
  );

  typedef struct {
    int          cyc;
    logic [3:0]  cmd;
    logic        err;
    logic [3:0]  banks;
    logic [1:0]  lp;
    logic [12:0] mb;
    logic [12:0] me;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc_cnt = 0;
  int n_chk = 0;
  int n_bad = 0;

  logic [3:0]  eb;
  logic [1:0]  el;
  logic [12:0] ebase, eext;

  localparam logic [3:0] P_MRS = 4'b0000, P_NOP = 4'b0111, P_DES = 4'b1111,
                         P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                         P_PRE = 4'b0010, P_BST = 4'b0110, P_REF = 4'b0001;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc < cyc_cnt) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " cmd"},   32'(cmd_code),    32'(e.cmd));
      chk({e.tag, " err"},   32'(cmd_err),     32'(e.err));
      chk({e.tag, " banks"}, 32'(bank_active), 32'(e.banks));
      chk({e.tag, " lp"},    32'(lp_state),    32'(e.lp));
      chk({e.tag, " mbase"}, 32'(mode_base),   32'(e.mb));
      chk({e.tag, " mext"},  32'(mode_ext),    32'(e.me));
      chk({e.tag, " dll"},   32'(dll_off),     32'(e.me[0]));
      chk({e.tag, " drv"},   32'(half_drive),  32'(e.me[1]));
    end
  end

  task automatic issue(input logic cp, input logic cc, input logic [3:0] pat,
                       input logic [12:0] a, input logic [1:0] b,
                       input cmd_e ecmd, input logic eerr, input string tag);
    exp_t e;
    @(negedge clk);
    cke_prev = cp; cke_cur = cc;
    {cs_n, ras_n, cas_n, we_n} = pat;
    addr = a; ba = b;
    e.cyc = cyc_cnt; e.cmd = ecmd; e.err = eerr; e.banks = eb; e.lp = el;
    e.mb = ebase; e.me = eext; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic op(input logic [3:0] pat, input logic [12:0] a, input logic [1:0] b,
                    input cmd_e ecmd, input logic eerr, input string tag);
    issue(1'b1, 1'b1, pat, a, b, ecmd, eerr, tag);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cke_prev = 1'b1; cke_cur = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_DES;
    addr = '0; ba = '0;
    eb = '0; el = '0; ebase = '0; eext = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset cmd",   32'(cmd_code),    32'd0);
    chk("R1 reset err",   32'(cmd_err),     32'd0);
    chk("R1 reset banks", 32'(bank_active), 32'd0);
    chk("R1 reset lp",    32'(lp_state),    32'd0);
    chk("R1 reset modes", 32'({mode_base, mode_ext}), 32'd0);
    rst_n = 1'b1;

    op(P_DES, 13'h0, 2'd0, CMD_DESEL, 1'b0, "R2 deselect");
    op(P_NOP, 13'h0, 2'd0, CMD_NOP,   1'b0, "R2 nop");
    ebase = 13'h0032;
    op(P_MRS, 13'h0032, 2'b00, CMD_MRS, 1'b0, "R9 base load");
    eext = 13'h0003;
    op(P_MRS, 13'h0003, 2'b01, CMD_EMRS, 1'b0, "R10 ext load");
    op(P_MRS, 13'h0004, 2'b01, CMD_EMRS, 1'b1, "R10 ext A2 set");
    op(P_MRS, 13'h0008, 2'b01, CMD_EMRS, 1'b1, "R10 ext reserved");
    op(P_MRS, 13'h0001, 2'b11, CMD_EMRS, 1'b1, "R9 ba 11");
    ebase = 13'h0021;
    op(P_MRS, 13'h0021, 2'b10, CMD_MRS, 1'b0, "R9 ba 10 base");

    eb = 4'b0010;
    op(P_ACT, 13'h0, 2'd1, CMD_ACT, 1'b0, "R3 act bank1");
    op(P_ACT, 13'h0, 2'd1, CMD_ACT, 1'b1, "R3 act active");
    op(P_RD,  13'h0, 2'd2, CMD_RD,  1'b1, "R4 read idle");
    op(P_WR,  13'h0, 2'd2, CMD_WR,  1'b1, "R4 write idle");
    op(P_MRS, 13'h0055, 2'b00, CMD_MRS, 1'b1, "R8 load with active");
    op(P_RD,  13'h0, 2'd1, CMD_RD,  1'b0, "R2 read");
    op(P_WR,  13'h0, 2'd1, CMD_WR,  1'b0, "R2 write");
    op(P_BST, 13'h0, 2'd0, CMD_BST, 1'b0, "R2 burst stop");
    op(P_REF, 13'h0, 2'd0, CMD_REF, 1'b0, "R2 refresh");
    eb = 4'b1010;
    op(P_ACT, 13'h0, 2'd3, CMD_ACT, 1'b0, "R3 act bank3");
    eb = 4'b1000;
    op(P_PRE, 13'h0000, 2'd1, CMD_PRE, 1'b0, "R5 precharge one");
    eb = 4'b0000;
    op(P_PRE, 13'h0400, 2'd1, CMD_PREA, 1'b0, "R5 precharge all");
    op(P_MRS, 13'h0040, 2'b00, CMD_MRS, 1'b1, "R8 load rp+1");
    op(P_MRS, 13'h0040, 2'b00, CMD_MRS, 1'b1, "R8 load rp+2");
    ebase = 13'h0040;
    op(P_MRS, 13'h0040, 2'b00, CMD_MRS, 1'b0, "R8 load at rp");

    eb = 4'b0001;
    op(P_ACT, 13'h0, 2'd0, CMD_ACT, 1'b0, "R6 act bank0");
    eb = 4'b0000;
    op(P_RD,  13'h0400, 2'd0, CMD_RDA, 1'b0, "R6 read autopre");
    op(P_NOP, 13'h0, 2'd0, CMD_NOP, 1'b0, "R6 n+1");
    op(P_MRS, 13'h0011, 2'b00, CMD_MRS, 1'b1, "R8 load during lock");
    op(P_NOP, 13'h0, 2'd0, CMD_NOP, 1'b0, "R6 n+3");
    op(P_ACT, 13'h0, 2'd0, CMD_ACT, 1'b1, "R6 act at n+4");
    eb = 4'b0001;
    op(P_ACT, 13'h0, 2'd0, CMD_ACT, 1'b0, "R6 act at n+5");

    eb = 4'b0000;
    op(P_WR, 13'h0400, 2'd0, CMD_WRA, 1'b0, "R7 write autopre");
    for (int i = 1; i <= 6; i++) op(P_NOP, 13'h0, 2'd0, CMD_NOP, 1'b0, "R7 wait");
    op(P_ACT, 13'h0, 2'd0, CMD_ACT, 1'b1, "R7 act at m+7");
    eb = 4'b0001;
    op(P_ACT, 13'h0, 2'd0, CMD_ACT, 1'b0, "R7 act at m+8");
    eb = 4'b0000;
    op(P_PRE, 13'h0, 2'd0, CMD_PRE, 1'b0, "R5 precharge bank0");

    el = 2'd2;
    issue(1'b1, 1'b0, P_NOP, 13'h0, 2'd0, CMD_PDE, 1'b0, "R12 precharge pd");
    issue(1'b0, 1'b0, P_ACT, 13'h0, 2'd2, CMD_NOP, 1'b0, "R12 ignored in pd");
    el = 2'd0;
    issue(1'b0, 1'b1, P_NOP, 13'h0, 2'd0, CMD_PDX, 1'b0, "R12 pd exit");
    eb = 4'b0100;
    op(P_ACT, 13'h0, 2'd2, CMD_ACT, 1'b0, "R3 act bank2");
    el = 2'd3;
    issue(1'b1, 1'b0, P_DES, 13'h0, 2'd0, CMD_PDE, 1'b0, "R12 active pd");
    el = 2'd0;
    issue(1'b0, 1'b1, P_NOP, 13'h0, 2'd0, CMD_PDX, 1'b0, "R12 apd exit");
    issue(1'b1, 1'b0, P_REF, 13'h0, 2'd0, CMD_SRE, 1'b1, "R11 self ref active");
    eb = 4'b0000;
    op(P_PRE, 13'h0, 2'd2, CMD_PRE, 1'b0, "R5 precharge bank2");
    el = 2'd1;
    issue(1'b1, 1'b0, P_REF, 13'h0, 2'd0, CMD_SRE, 1'b0, "R11 self ref entry");
    issue(1'b0, 1'b0, P_NOP, 13'h0, 2'd0, CMD_NOP, 1'b0, "R11 self ref hold");
    el = 2'd0;
    issue(1'b0, 1'b1, P_NOP, 13'h0, 2'd0, CMD_PDX, 1'b0, "R11 self ref exit");
    issue(1'b1, 1'b0, P_ACT, 13'h0, 2'd1, CMD_ACT, 1'b1, "R12 act on cke fall");
    op(P_NOP, 13'h0, 2'd0, CMD_NOP, 1'b0, "R4 state kept");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule